// File: doc/BRIEF.md
# Byte-Serial Processor Core

This block is a small processor core that runs instructions of variable length, reading one byte per cycle from a 64 KB byte-wide memory through a synchronous read port. The port has one cycle of latency. The core holds four 8-bit general registers, a 16-bit program counter and two flags, zero and carry. It supports:

- moves from an immediate or from another register;
- add and subtract, each with a register or an immediate operand;
- an unconditional jump and two jumps that depend on the zero flag;
- a halt.

The core drives the memory address and a read enable. A surrounding memory returns the addressed byte on the next cycle. The core has no write path to memory. A halted output and debug views of the registers and flags let a system or a bench observe the results of a program.

Top module: `byte_cpu`

## Requirements
- R1: While reset is held, all four registers, the zero flag and the carry flag read 0, halted is 0, and the memory address is 0x0000, where fetching begins.
- R2: Move with an immediate (opcode 0x01) and move from a register (opcode 0x08) take three bytes: opcode, destination register byte, then source byte. Register bytes are A=0, B=1, C=2, D=3. A move leaves the zero and carry flags unchanged.
- R3: Add, with a register source (0x02) or an immediate source (0x0A), writes the 8-bit wrapped sum to the destination. It sets carry to the unsigned carry out of bit 7.
- R4: Subtract, with a register source (0x03) or an immediate source (0x0B), writes the 8-bit wrapped difference to the destination. It sets carry when the subtrahend exceeds the minuend (a borrow).
- R5: After an add or a subtract, the zero flag is 1 exactly when the written result is 0.
- R6: An add or a subtract whose destination byte is above 3 writes no register. Such an instruction sets zero to 1 and clears carry.
- R7: Jump (0x04) loads the program counter with the 16-bit target held in the next two bytes, low byte first. Fetching continues at that target.
- R8: The conditional jumps are 0x05, taken only when zero is 1, and 0x06, taken only when zero is 0. When the jump is not taken, execution continues with the byte after the three-byte instruction.
- R9: Halt (0x07) and every undefined opcode assert halted. Halted stays set until reset. While halted, the read enable is low and the registers and flags stay frozen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Byte address presented to the memory |
| mem_en | output | 1 | Read enable; low once halted |
| mem_rdata | input | 8 | Byte read from the address presented on the previous cycle |
| halted | output | 1 | Sticky halt indication |
| dbg_regs | output | 32 | Register view, register n at bits [8n+7:8n] |
| dbg_zero | output | 1 | Zero flag |
| dbg_carry | output | 1 | Carry/borrow flag |

## Verification
The bench runs short programs. It compares the final registers and flags with those of a bench-side interpreter of the instruction set. Directed programs target the following corner cases:

- An 8-bit wrap that must raise both carry and zero. A design that drops bit 8 would leave carry clear.
- A borrow. A design that inverts the sense of carry on subtract would be caught here.
- A move placed after a flag-setting operation. A design that lets moves touch the flags would corrupt them.
- An out-of-range destination. A design that wrote the register anyway, or kept the old carry, would fail.
- Jump targets placed above 0xFF. Swapped target bytes would send fetching into zeros and halt early.
- Conditional jumps both taken and not taken. A design with a wrong skip length would execute the wrong code.

Undefined opcodes and halt are checked for stickiness over many idle cycles. Random instruction mixes cover the arithmetic broadly.

// File: rtl/bcpu_pkg.sv
package bcpu_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 16;
  localparam int NUM_REGS = 4;

  localparam logic [7:0] OPC_MOV_IMM = 8'h01;
  localparam logic [7:0] OPC_ADD_REG = 8'h02;
  localparam logic [7:0] OPC_SUB_REG = 8'h03;
  localparam logic [7:0] OPC_JMP     = 8'h04;
  localparam logic [7:0] OPC_JZ      = 8'h05;
  localparam logic [7:0] OPC_JNZ     = 8'h06;
  localparam logic [7:0] OPC_HALT    = 8'h07;
  localparam logic [7:0] OPC_MOV_REG = 8'h08;
  localparam logic [7:0] OPC_ADD_IMM = 8'h0A;
  localparam logic [7:0] OPC_SUB_IMM = 8'h0B;

  typedef enum logic [2:0] {
    ST_BOOT,   // issue first read at current pc
    ST_OPC,    // opcode byte on read data
    ST_ARG1,   // first operand byte on read data
    ST_ARG2,   // second operand byte on read data, execute
    ST_STOP    // halted
  } cpu_state_e;

  // opcodes that continue into a three-byte instruction
  function automatic logic opc_runs(input logic [7:0] opc);
    return opc inside {OPC_MOV_IMM, OPC_MOV_REG, OPC_ADD_REG, OPC_ADD_IMM,
                       OPC_SUB_REG, OPC_SUB_IMM, OPC_JMP, OPC_JZ, OPC_JNZ};
  endfunction

  function automatic logic opc_is_mov(input logic [7:0] opc);
    return (opc == OPC_MOV_IMM) || (opc == OPC_MOV_REG);
  endfunction

  function automatic logic opc_is_arith(input logic [7:0] opc);
    return opc inside {OPC_ADD_REG, OPC_ADD_IMM, OPC_SUB_REG, OPC_SUB_IMM};
  endfunction

  function automatic logic opc_is_sub(input logic [7:0] opc);
    return (opc == OPC_SUB_REG) || (opc == OPC_SUB_IMM);
  endfunction

  function automatic logic opc_src_is_reg(input logic [7:0] opc);
    return opc inside {OPC_MOV_REG, OPC_ADD_REG, OPC_SUB_REG};
  endfunction

  // returns {carry_out, sum}
  function automatic logic [DATA_W:0] add_wc(input logic [DATA_W-1:0] a,
                                             input logic [DATA_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // returns {borrow, difference}
  function automatic logic [DATA_W:0] sub_wb(input logic [DATA_W-1:0] a,
                                             input logic [DATA_W-1:0] b);
    return {1'b0, a} - {1'b0, b};
  endfunction
endpackage

// File: rtl/bcpu_regfile.sv
module bcpu_regfile #(
  parameter int DW   = bcpu_pkg::DATA_W,
  parameter int NREG = bcpu_pkg::NUM_REGS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic [DW-1:0]    rd_sel_a,
  input  logic [DW-1:0]    rd_sel_b,
  output logic [DW-1:0]    rd_data_a,
  output logic [DW-1:0]    rd_data_b,
  output logic [NREG*DW-1:0] view
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  regs_q[g] <= '0;
      else if (wr_en && (wr_sel == DW'(g)))        regs_q[g] <= wr_data;
    end
    assign view[g*DW +: DW] = regs_q[g];
  end

  // selector bytes outside the file read as zero
  always_comb begin
    rd_data_a = '0;
    rd_data_b = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_sel_a == DW'(i)) rd_data_a = regs_q[i];
      if (rd_sel_b == DW'(i)) rd_data_b = regs_q[i];
    end
  end
endmodule

// File: rtl/bcpu_alu.sv
module bcpu_alu #(
  parameter int DW = bcpu_pkg::DATA_W
) (
  input  logic          do_sub,
  input  logic          dst_ok,
  input  logic [DW-1:0] lhs,
  input  logic [DW-1:0] rhs,
  output logic [DW-1:0] result,
  output logic          carry
);
  import bcpu_pkg::*;
  logic [DW:0] wide;

  always_comb begin
    wide = do_sub ? sub_wb(lhs, rhs) : add_wc(lhs, rhs);
    if (!dst_ok) wide = '0;   // bad destination: result 0, no carry
    result = wide[DW-1:0];
    carry  = wide[DW];
  end
endmodule

// File: rtl/bcpu_ctrl.sv
module bcpu_ctrl #(
  parameter int DW = bcpu_pkg::DATA_W,
  parameter int AW = bcpu_pkg::ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW-1:0]        rdata,
  input  logic                 zero_flag,
  output logic [AW-1:0]        fetch_addr,
  output logic                 fetch_en,
  output bcpu_pkg::cpu_state_e state,
  output logic [DW-1:0]        opc,
  output logic [DW-1:0]        arg1,
  output logic                 take_jump,
  output logic                 stopped
);
  import bcpu_pkg::*;
  localparam int TGT_HI_W = AW - DW;

  cpu_state_e    st_q;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] opc_q, arg1_q;
  logic [AW-1:0] target;

  assign target = {rdata[TGT_HI_W-1:0], arg1_q};

  always_comb begin
    take_jump = 1'b0;
    if (st_q == ST_ARG2) begin
      unique case (opc_q)
        OPC_JMP: take_jump = 1'b1;
        OPC_JZ:  take_jump = zero_flag;
        OPC_JNZ: take_jump = !zero_flag;
        default: take_jump = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_BOOT;
      pc_q   <= '0;
      opc_q  <= '0;
      arg1_q <= '0;
    end else begin
      unique case (st_q)
        ST_BOOT: begin
          pc_q <= pc_q + 1'b1;
          st_q <= ST_OPC;
        end
        ST_OPC: begin
          if (opc_runs(rdata)) begin
            opc_q <= rdata;
            pc_q  <= pc_q + 1'b1;
            st_q  <= ST_ARG1;
          end else begin
            st_q  <= ST_STOP;
          end
        end
        ST_ARG1: begin
          arg1_q <= rdata;
          pc_q   <= pc_q + 1'b1;
          st_q   <= ST_ARG2;
        end
        ST_ARG2: begin
          if (take_jump) begin
            pc_q <= target;
            st_q <= ST_BOOT;
          end else begin
            pc_q <= pc_q + 1'b1;
            st_q <= ST_OPC;
          end
        end
        default: st_q <= ST_STOP;
      endcase
    end
  end

  assign fetch_addr = pc_q;
  assign fetch_en   = (st_q != ST_STOP);
  assign stopped    = (st_q == ST_STOP);
  assign state      = st_q;
  assign opc        = opc_q;
  assign arg1       = arg1_q;
endmodule

// File: rtl/byte_cpu.sv
module byte_cpu #(
  parameter int DW   = bcpu_pkg::DATA_W,
  parameter int AW   = bcpu_pkg::ADDR_W,
  parameter int NREG = bcpu_pkg::NUM_REGS
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [AW-1:0]      mem_addr,
  output logic               mem_en,
  input  logic [DW-1:0]      mem_rdata,
  output logic               halted,
  output logic [NREG*DW-1:0] dbg_regs,
  output logic               dbg_zero,
  output logic               dbg_carry
);
  import bcpu_pkg::*;

  cpu_state_e    state;
  logic [DW-1:0] opc, arg1;
  logic          take_jump;
  logic          zf_q, cf_q;

  // named events for the checker
  logic          exec_mov, exec_alu, dst_valid;
  logic [DW-1:0] dst_val, src_reg_val, src_val;
  logic [DW-1:0] alu_res, wr_data;
  logic          alu_cy, wr_en;

  bcpu_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rdata(mem_rdata), .zero_flag(zf_q),
    .fetch_addr(mem_addr), .fetch_en(mem_en), .state(state),
    .opc(opc), .arg1(arg1), .take_jump(take_jump), .stopped(halted)
  );

  assign exec_mov  = (state == ST_ARG2) && opc_is_mov(opc);
  assign exec_alu  = (state == ST_ARG2) && opc_is_arith(opc);
  assign dst_valid = (arg1 < DW'(NREG));
  assign src_val   = opc_src_is_reg(opc) ? src_reg_val : mem_rdata;

  bcpu_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(arg1), .wr_data(wr_data),
    .rd_sel_a(arg1), .rd_sel_b(mem_rdata),
    .rd_data_a(dst_val), .rd_data_b(src_reg_val), .view(dbg_regs)
  );

  bcpu_alu #(.DW(DW)) u_alu (
    .do_sub(opc_is_sub(opc)), .dst_ok(dst_valid),
    .lhs(dst_val), .rhs(src_val), .result(alu_res), .carry(alu_cy)
  );

  assign wr_en   = (exec_mov || exec_alu) && dst_valid;
  assign wr_data = exec_mov ? src_val : alu_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zf_q <= 1'b0;
      cf_q <= 1'b0;
    end else if (exec_alu) begin
      zf_q <= (alu_res == '0);
      cf_q <= alu_cy;
    end
  end

  assign dbg_zero  = zf_q;
  assign dbg_carry = cf_q;
endmodule

// File: rtl/bcpu_checker.sv
module bcpu_checker #(
  parameter int DW   = bcpu_pkg::DATA_W,
  parameter int AW   = bcpu_pkg::ADDR_W,
  parameter int NREG = bcpu_pkg::NUM_REGS
) (
  input logic               clk,
  input logic               rst_n,
  input logic               halted,
  input logic               mem_en,
  input logic [AW-1:0]      mem_addr,
  input logic [DW-1:0]      mem_rdata,
  input logic [NREG*DW-1:0] dbg_regs,
  input logic               zf,
  input logic               cf,
  input logic               exec_mov,
  input logic               exec_alu,
  input logic               dst_valid,
  input logic               take_jump,
  input logic [DW-1:0]      arg1
);
  logic [DW-1:0] last_dst;
  logic [DW-1:0] last_dst_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_dst <= '0;
    else        last_dst <= arg1;
  end

  always_comb begin
    last_dst_val = '0;
    for (int i = 0; i < NREG; i++)
      if (last_dst == DW'(i)) last_dst_val = dbg_regs[i*DW +: DW];
  end

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R9
  AST_HALT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_en); // R9
  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(dbg_regs) && $stable(zf) && $stable(cf))); // R9
  AST_MOV_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    exec_mov |=> ($stable(zf) && $stable(cf))); // R2
  AST_BAD_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_alu && !dst_valid) |=> (zf && !cf && $stable(dbg_regs))); // R6
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_alu && dst_valid) |=> (zf == (last_dst_val == '0))); // R5
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    take_jump |=> (mem_addr == AW'({$past(mem_rdata), $past(arg1)}))); // R7
endmodule

bind byte_cpu bcpu_checker #(.DW(DW), .AW(AW), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .halted(halted), .mem_en(mem_en),
  .mem_addr(mem_addr), .mem_rdata(mem_rdata), .dbg_regs(dbg_regs),
  .zf(dbg_zero), .cf(dbg_carry), .exec_mov(exec_mov), .exec_alu(exec_alu),
  .dst_valid(dst_valid), .take_jump(take_jump), .arg1(arg1)
);

// File: tb/test_byte_cpu.sv
module test_byte_cpu;
  localparam int MEMSZ = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_en;
  logic [7:0]  mem_rdata = 8'h00;
  logic        halted;
  logic [31:0] dbg_regs;
  logic        dbg_zero, dbg_carry;

  logic [7:0]  mem [MEMSZ];
  int          wp;
  int          n_cmp = 0;
  int          n_bad = 0;
  int          cycles = 0;

  int          m_reg [4];
  bit          m_z, m_c;

  always #4 clk = ~clk;  // 125 MHz

  byte_cpu i_byte_cpu (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_en(mem_en),
    .mem_rdata(mem_rdata), .halted(halted), .dbg_regs(dbg_regs),
    .dbg_zero(dbg_zero), .dbg_carry(dbg_carry)
  );

  always @(posedge clk) if (mem_en) mem_rdata <= mem[mem_addr[8:0]];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got %0d cycles expected under 150000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MEMSZ; i++) mem[i] = 8'h00;
    wp = 0;
  endtask

  task automatic put(input int b);
    mem[wp] = 8'(b);
    wp++;
  endtask

  task automatic ins3(input int opc, input int x, input int y);
    put(opc); put(x); put(y);
  endtask

  // independent interpreter of the instruction set
  task automatic model_run();
    int pc, op, d, s, a, b, r;
    bit go;
    pc = 0; go = 1;
    for (int i = 0; i < 4; i++) m_reg[i] = 0;
    m_z = 0; m_c = 0;
    for (int step = 0; step < 4000 && go; step++) begin
      op = mem[pc % MEMSZ];
      d  = mem[(pc + 1) % MEMSZ];
      s  = mem[(pc + 2) % MEMSZ];
      case (op)
        1, 8: begin
          b = (op == 8) ? ((s < 4) ? m_reg[s] : 0) : s;
          if (d < 4) m_reg[d] = b;
          pc += 3;
        end
        2, 10, 3, 11: begin
          a = (d < 4) ? m_reg[d] : 0;
          b = (op == 2 || op == 3) ? ((s < 4) ? m_reg[s] : 0) : s;
          if (d < 4) begin
            if (op == 2 || op == 10) begin r = a + b; m_c = (r > 255); end
            else begin r = a - b; m_c = (a < b); end
            r = r & 255;
            m_reg[d] = r;
          end else begin
            r = 0; m_c = 0;
          end
          m_z = (r == 0);
          pc += 3;
        end
        4: pc = d + 256 * s;
        5: pc = m_z ? d + 256 * s : pc + 3;
        6: pc = !m_z ? d + 256 * s : pc + 3;
        default: go = 0;
      endcase
    end
  endtask

  task automatic run_and_compare(input string req);
    int n;
    model_run();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "reset regs", int'(dbg_regs), 0);
    check("R1", "reset flags", int'({dbg_zero, dbg_carry}), 0);
    check("R1", "reset halted", int'(halted), 0);
    check("R1", "reset address", int'(mem_addr), 0);
    rst_n = 1'b1;
    n = 0;
    while (!halted && n < 6000) begin
      @(negedge clk);
      n++;
    end
    check(req, "halted", int'(halted), 1);
    for (int i = 0; i < 4; i++)
      check(req, $sformatf("reg%0d", i), int'(dbg_regs[i*8 +: 8]), m_reg[i]);
    check(req, "zero", int'(dbg_zero), int'(m_z));
    check(req, "carry", int'(dbg_carry), int'(m_c));
  endtask

  initial begin
    int seed;
    int k;
    seed = 32'h5EED;
    k = $urandom(seed);

    // R2 R3 R4: moves and basic arithmetic
    clear_mem();
    ins3(1, 0, 10); ins3(1, 1, 5); ins3(10, 0, 2); ins3(11, 0, 2);
    ins3(8, 2, 1); ins3(2, 2, 0); put(7);
    run_and_compare("R2/R3");
    check("R3", "c = b + a", int'(dbg_regs[23:16]), 15);

    // R3 R5: wrap to zero with carry, then a move keeps flags (R2)
    clear_mem();
    ins3(1, 0, 255); ins3(10, 0, 1); ins3(1, 1, 7); put(7);
    run_and_compare("R5");
    check("R3", "wrap carry", int'(dbg_carry), 1);
    check("R2", "move keeps zero", int'(dbg_zero), 1);

    // R3: carry out without zero
    clear_mem();
    ins3(1, 0, 200); ins3(10, 0, 100); put(7);
    run_and_compare("R3");
    check("R3", "200+100 result", int'(dbg_regs[7:0]), 44);

    // R4: borrow, then register subtract to zero
    clear_mem();
    ins3(1, 0, 3); ins3(11, 0, 5); ins3(1, 3, 254); put(7);
    run_and_compare("R4");
    check("R4", "borrow flag", int'(dbg_carry), 1);
    clear_mem();
    ins3(1, 0, 254); ins3(1, 1, 254); ins3(3, 0, 1); put(7);
    run_and_compare("R4");
    check("R5", "sub to zero", int'(dbg_zero), 1);

    // R6: bad destination after a borrow
    clear_mem();
    ins3(1, 0, 0); ins3(11, 0, 1); ins3(3, 9, 0); ins3(10, 200, 4); put(7);
    run_and_compare("R6");
    check("R6", "carry cleared", int'(dbg_carry), 0);
    check("R6", "zero set", int'(dbg_zero), 1);
    check("R6", "A untouched", int'(dbg_regs[7:0]), 255);

    // R7: jump to a target above 0xFF, low byte first
    clear_mem();
    ins3(4, 8'h20, 8'h01); ins3(1, 0, 1); put(7);
    wp = 16'h0120; ins3(1, 1, 8'h55); put(7);
    run_and_compare("R7");
    check("R7", "landed at target", int'(dbg_regs[15:8]), 8'h55);

    // R8: jz taken, jnz not taken
    clear_mem();
    ins3(1, 0, 1); ins3(11, 0, 1); ins3(5, 8'h40, 0); ins3(1, 2, 8'hEE); put(7);
    wp = 8'h40; ins3(1, 3, 8'h11); ins3(6, 8'h80, 0); ins3(1, 1, 8'h22); put(7);
    run_and_compare("R8");
    check("R8", "jnz not taken fell through", int'(dbg_regs[15:8]), 8'h22);
    // R8: jz not taken, jnz taken
    clear_mem();
    ins3(1, 0, 2); ins3(11, 0, 1); ins3(5, 8'h60, 0); ins3(1, 2, 3);
    ins3(6, 8'h70, 0); ins3(1, 2, 4); put(7);
    wp = 8'h70; ins3(1, 3, 9); put(7);
    run_and_compare("R8");
    check("R8", "jnz taken skipped move", int'(dbg_regs[23:16]), 3);

    // R9: halt and undefined opcode are sticky, state frozen
    clear_mem();
    ins3(1, 0, 5); put(7); ins3(1, 0, 6); put(7);
    run_and_compare("R9");
    repeat (30) @(negedge clk);
    check("R9", "still halted", int'(halted), 1);
    check("R9", "read disabled", int'(mem_en), 0);
    check("R9", "A frozen", int'(dbg_regs[7:0]), 5);
    clear_mem();
    ins3(1, 1, 33); put(8'h09); ins3(1, 1, 44); put(7);
    run_and_compare("R9");
    check("R9", "undefined opcode stops", int'(dbg_regs[15:8]), 33);

    // random mixes: R3 R4 R5 R6 and R2
    for (int p = 0; p < 24; p++) begin
      clear_mem();
      for (int j = 0; j < 10; j++) begin
        int sel, d;
        sel = $urandom_range(0, 5);
        d   = ($urandom_range(0, 9) == 0) ? $urandom_range(4, 255) : $urandom_range(0, 3);
        case (sel)
          0: ins3(1, d % 4, $urandom_range(0, 255));
          1: ins3(8, d % 4, $urandom_range(0, 3));
          2: ins3(2, d, $urandom_range(0, 3));
          3: ins3(10, d, $urandom_range(0, 255));
          4: ins3(3, d, $urandom_range(0, 3));
          default: ins3(11, d, $urandom_range(0, 255));
        endcase
      end
      put(7);
      run_and_compare("R3/R4/R5/R6 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule